// File: doc/BRIEF.md
# Entropy-Backed Random Data Register

This block holds a single word of random data taken from an external entropy source, together with a flag that tells whether that word is of FIPS quality. Software sees two words through a plain read port: a data word and a status word. The block fetches entropy with a request/acknowledge handshake. The source answers with the word and its quality flag in the cycle it acknowledges.

Reading the data word while it is valid hands the word to software, empties the holder and at once asks the source for a fresh word. Reading while the holder is empty returns zero and leaves the outstanding request untouched. Reading the status word, or any unmapped address, changes nothing.

Control is a two-state machine. In `ST_FILL` the request is driven high. The transition `FILL_TO_FULL` is taken on an acknowledge and captures the word and flag. In `ST_FULL` the request is low and any acknowledge is ignored. The transition `FULL_TO_FILL` is taken when software reads the data word. Reset enters `ST_FILL`, so a request is pending as soon as reset is released.

Top module: `rnd_word_reg`

## Requirements
- R1: After reset the holder is empty, `ent_req` is 1, and reads of both the status word and the data word return 0.
- R2: `ent_req` stays 1 until a cycle with `ent_ack` high. The word and flag presented in that cycle are captured, and from the next cycle the holder is valid and `ent_req` is 0.
- R3: A read of the data word (address `DATA_IDX`, default 0) while valid returns the held word in the same cycle. From the next cycle the holder is empty and `ent_req` is 1.
- R4: A read of the data word while empty returns 0 and keeps `ent_req` at 1.
- R5: The status word (address `STAT_IDX`, default 1) has bit 0 = valid and bit 1 = FIPS flag of the held word when valid (0 when empty). All other bits are 0.
- R6: Reading the status word has no side effect: the held word, validity and request are unchanged.
- R7: A data read in the same cycle as an acknowledge sees the empty state and returns 0. The acknowledged word is still captured and is returned by the next data read.
- R8: A read of any other address returns 0 and has no side effect.
- R9: An acknowledge while the holder is valid (no request outstanding) is ignored and the held word is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read strobe, one read per cycle it is high |
| rd_addr | input | ADDR_W | Word index of the read |
| rd_data | output | WIDTH | Read result in the same cycle, 0 when `rd_en` is low |
| ent_req | output | 1 | Request for a new word from the entropy source |
| ent_ack | input | 1 | Acknowledge from the source, qualifies `ent_data` and `ent_fips` |
| ent_data | input | WIDTH | Random word from the source |
| ent_fips | input | 1 | Quality flag of `ent_data` |

## Verification
The properties assume that the read address and strobe are known values in every cycle after reset. They do not assume that the source acknowledges only while requested: an acknowledge during `ST_FULL` must be ignored, and the stimulus deliberately produces it. The bench source waits a random number of cycles before acknowledging and sometimes acknowledges without a request. Random reads hit the data, status and unmapped addresses, and directed cases put a read and an acknowledge in the same cycle.

// File: rtl/rnd_reg_pkg.sv
package rnd_reg_pkg;

    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_FULL = 1'b1
    } fill_state_e;

endpackage

// File: rtl/rnd_fill_fsm.sv
module rnd_fill_fsm
    import rnd_reg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    input  logic consume,
    output logic req,
    output logic full,
    output logic capture
);

    fill_state_e state_q;
    fill_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (ack)     state_d = ST_FULL;
            ST_FULL: if (consume) state_d = ST_FILL;
            default:              state_d = ST_FILL;
        endcase
    end

    always_comb begin
        req     = 1'b0;
        full    = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_FILL: begin
                req     = 1'b1;
                capture = ack;
            end
            ST_FULL: begin
                full = 1'b1;
            end
            default: begin
                req = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/rnd_word_store.sv
module rnd_word_store #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             consume,
    input  logic [WIDTH-1:0] din,
    input  logic             fips_in,
    output logic [WIDTH-1:0] dout,
    output logic             fips_out
);

    logic [WIDTH-1:0] word_q;
    logic             fips_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            fips_q <= 1'b0;
        end else if (capture) begin
            word_q <= din;
            fips_q <= fips_in;
        end else if (consume) begin
            word_q <= '0;
            fips_q <= 1'b0;
        end
    end

    assign dout     = word_q;
    assign fips_out = fips_q;

endmodule

// File: rtl/rnd_read_mux.sv
module rnd_read_mux #(
    parameter int WIDTH    = 32,
    parameter int ADDR_W   = 3,
    parameter int DATA_IDX = 0,
    parameter int STAT_IDX = 1
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              full,
    input  logic [WIDTH-1:0]  word,
    input  logic              fips,
    output logic [WIDTH-1:0]  rd_data,
    output logic              data_hit
);

    localparam int PAD_W = WIDTH - 2;

    logic             stat_hit;
    logic [WIDTH-1:0] stat_word;

    assign data_hit  = rd_en && (rd_addr == ADDR_W'(DATA_IDX));
    assign stat_hit  = rd_en && (rd_addr == ADDR_W'(STAT_IDX));
    assign stat_word = {{PAD_W{1'b0}}, fips & full, full};

    always_comb begin
        rd_data = '0;
        if (data_hit && full) begin
            rd_data = word;
        end else if (stat_hit) begin
            rd_data = stat_word;
        end
    end

endmodule

// File: rtl/rnd_word_reg.sv
module rnd_word_reg #(
    parameter int WIDTH    = 32,
    parameter int ADDR_W   = 3,
    parameter int DATA_IDX = 0,
    parameter int STAT_IDX = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WIDTH-1:0]  rd_data,
    output logic              ent_req,
    input  logic              ent_ack,
    input  logic [WIDTH-1:0]  ent_data,
    input  logic              ent_fips
);

    logic             full_q;
    logic             capture;
    logic             data_hit;
    logic             consume;
    logic [WIDTH-1:0] held_word;
    logic             held_fips;

    assign consume = data_hit && full_q;

    rnd_fill_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ent_ack),
        .consume (consume),
        .req     (ent_req),
        .full    (full_q),
        .capture (capture)
    );

    rnd_word_store #(
        .WIDTH (WIDTH)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .consume  (consume),
        .din      (ent_data),
        .fips_in  (ent_fips),
        .dout     (held_word),
        .fips_out (held_fips)
    );

    rnd_read_mux #(
        .WIDTH    (WIDTH),
        .ADDR_W   (ADDR_W),
        .DATA_IDX (DATA_IDX),
        .STAT_IDX (STAT_IDX)
    ) u_mux (
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .full     (full_q),
        .word     (held_word),
        .fips     (held_fips),
        .rd_data  (rd_data),
        .data_hit (data_hit)
    );

endmodule

// File: rtl/rnd_word_reg_chk.sv
module rnd_word_reg_chk #(
    parameter int WIDTH    = 32,
    parameter int ADDR_W   = 3,
    parameter int DATA_IDX = 0,
    parameter int STAT_IDX = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [WIDTH-1:0]  rd_data,
    input logic              ent_req,
    input logic              ent_ack,
    input logic              full_q
);

    logic data_rd;
    logic stat_rd;
    assign data_rd = rd_en && (rd_addr == ADDR_W'(DATA_IDX));
    assign stat_rd = rd_en && (rd_addr == ADDR_W'(STAT_IDX));

    // R1
    empty_requests_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !full_q |-> ent_req);

    // R2
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_req && !ent_ack |=> ent_req);

    // R2
    ack_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_req && ent_ack |=> full_q && !ent_req);

    // R3
    consume_refills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd && full_q |=> !full_q && ent_req);

    // R4
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd && !full_q |-> rd_data == '0);

    // R6
    stat_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && full_q |=> full_q);

    // R9
    stray_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_q && !data_rd |=> full_q);

endmodule

bind rnd_word_reg rnd_word_reg_chk #(
    .WIDTH    (WIDTH),
    .ADDR_W   (ADDR_W),
    .DATA_IDX (DATA_IDX),
    .STAT_IDX (STAT_IDX)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .ent_req (ent_req),
    .ent_ack (ent_ack),
    .full_q  (full_q)
);

// File: tb/tb_rnd_word_reg.sv
module tb_rnd_word_reg;

    localparam int WIDTH  = 32;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [WIDTH-1:0]  rd_data;
    logic              ent_req;
    logic              ent_ack = 1'b0;
    logic [WIDTH-1:0]  ent_data = '0;
    logic              ent_fips = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;

    bit             exp_valid = 1'b0;
    logic [WIDTH-1:0] exp_word = '0;
    bit             exp_fips = 1'b0;

    always #4 clk = ~clk;

    rnd_word_reg dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .ent_req  (ent_req),
        .ent_ack  (ent_ack),
        .ent_data (ent_data),
        .ent_fips (ent_fips)
    );

    function automatic logic [WIDTH-1:0] exp_read(input logic [ADDR_W-1:0] a);
        if (a == A_DATA) return exp_valid ? exp_word : '0;
        if (a == A_STAT) return {30'd0, exp_fips & exp_valid, exp_valid};
        return '0;
    endfunction

    function automatic string auto_tag(input logic [ADDR_W-1:0] a);
        if (a == A_DATA) return exp_valid ? "R3" : "R4";
        if (a == A_STAT) return "R5";
        return "R8";
    endfunction

    task automatic check(input logic [WIDTH-1:0] got, input logic [WIDTH-1:0] exp,
                         input string tag, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic cyc(input bit rd, input logic [ADDR_W-1:0] a, input bit ack,
                       input logic [WIDTH-1:0] d, input bit f, input string tag);
        @(negedge clk);
        rd_en = rd; rd_addr = a; ent_ack = ack; ent_data = d; ent_fips = f;
        #1;
        check({31'd0, ent_req}, {31'd0, !exp_valid}, (tag == "") ? "R2" : tag, "request");
        if (rd) check(rd_data, exp_read(a), (tag == "") ? auto_tag(a) : tag, "read data");
        @(posedge clk);
        if (exp_valid) begin
            if (rd && a == A_DATA) begin
                exp_valid = 1'b0; exp_word = '0; exp_fips = 1'b0;
            end
        end else if (ack) begin
            exp_valid = 1'b1; exp_word = d; exp_fips = f;
        end
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int r;
        r = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cyc(1, A_STAT, 0, '0, 0, "R1");
        cyc(1, A_DATA, 0, '0, 0, "R1");
        // R4 repeated empty reads keep request
        cyc(1, A_DATA, 0, '0, 0, "R4");
        cyc(1, A_DATA, 0, '0, 0, "R4");
        // R2 capture with fips
        cyc(0, A_DATA, 0, '0, 0, "R2");
        cyc(0, A_DATA, 1, 32'hA5A5_0001, 1, "R2");
        cyc(0, A_DATA, 0, '0, 0, "R2");
        // R5 status with fips set
        cyc(1, A_STAT, 0, '0, 0, "R5");
        // R6 status reads do not consume
        cyc(1, A_STAT, 0, '0, 0, "R6");
        cyc(1, A_DATA, 0, '0, 0, "R6");
        // R3 consumed, empty again
        cyc(1, A_STAT, 0, '0, 0, "R3");
        cyc(1, A_DATA, 0, '0, 0, "R3");
        // R9 stray acknowledge while full
        cyc(0, A_DATA, 1, 32'h1234_5678, 0, "R9");
        cyc(0, A_DATA, 1, 32'hDEAD_BEEF, 1, "R9");
        cyc(1, A_STAT, 0, '0, 0, "R9");
        cyc(1, A_DATA, 0, '0, 0, "R9");
        // R7 read and acknowledge in the same cycle
        cyc(1, A_DATA, 1, 32'h0BAD_F00D, 1, "R7");
        cyc(1, A_DATA, 0, '0, 0, "R7");
        // R8 unmapped address while full
        cyc(0, A_DATA, 1, 32'h5555_AAAA, 0, "R8");
        cyc(1, 3'd5, 0, '0, 0, "R8");
        cyc(1, 3'd7, 0, '0, 0, "R8");
        cyc(1, A_DATA, 0, '0, 0, "R8");
        // random phase with a source of random latency
        for (int i = 0; i < 3000; i++) begin
            bit rd;
            bit ack;
            logic [ADDR_W-1:0] a;
            rd  = ($urandom % 3) == 0;
            a   = ($urandom % 2) ? A_DATA : ADDR_W'($urandom);
            ack = exp_valid ? (($urandom % 16) == 0) : (($urandom % 4) == 0);
            cyc(rd, a, ack, $urandom, 1'($urandom), "");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule